// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides whether a received frame is meant for this station by looking at its 48-bit destination address. It first compares the address against sixteen programmable exact-match slots. A slot only takes part in the comparison while its valid flag is set. When no slot matches, the block falls back to an imperfect hash check. It cuts a 12-bit window out of the two highest address bytes and uses it to pick one bit of a 4096-bit table. Most often this table is used to accept multicast groups.

Software fills the slots and the hash table through a single-cycle write port. The receive path presents the address, a 2-bit window-offset select and a one-cycle lookup strobe. One cycle after the strobe, the block raises `done` for one cycle. It reports whether the frame is accepted, and whether an exact slot caused the acceptance and which slot it was. The result stays on the outputs until the next lookup. Every acceptance through the hash path increments a saturating counter.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, every slot is invalid, every hash-table bit is zero, the counter is zero, and `done`, `accept` and `slotHit` are low. A lookup that follows reset is therefore rejected.
- R2: Writes are decoded as follows. `wrAddr` = 2*s writes slot s's low word, which holds address bytes 0..3 with byte 0 in bits 7:0. `wrAddr` = 2*s+1 writes slot s's high word: bits 15:0 hold bytes 5:4 (byte 4 in bits 7:0) and bit 31 is the valid flag. `wrAddr` = 128+w writes hash-table word w. Address byte k is `dstAddr[8k+7:8k]`.
- R3: When all six bytes equal those of a valid slot, the frame is accepted with `slotHit`=1 and `slotIdx` set to that slot. If any single byte differs, that slot does not match.
- R4: A slot whose valid flag is clear never matches, even when its stored address is equal to the looked-up one.
- R5: When several valid slots match, `slotIdx` reports the lowest-numbered one.
- R6: The hash value is ({byte5,byte4} >> n) masked to 12 bits. The shift n is 4, 3, 2 or 0 for `hashSel` values 0, 1, 2 and 3.
- R7: Bits 11:5 of the hash select the table word, and bits 4:0 select the bit within that word. A set bit accepts the frame with `slotHit`=0.
- R8: An exact slot match takes priority over the hash path. In that case the counter does not change, even when the hashed bit is set.
- R9: Every acceptance through the hash path alone adds one to `mcastCount`. Once the counter reaches all ones it stays there.
- R10: A frame that matches no valid slot and whose hashed bit is clear is rejected, with `accept`=0 and `slotHit`=0.
- R11: `done` is high exactly in the cycle after `lookupStb`. `accept`, `slotHit` and `slotIdx` change only at that point and hold their values until the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | 8 | Table word select (see R2) |
| wrData | input | 32 | Table write data |
| lookupStb | input | 1 | Start a lookup of `dstAddr` |
| dstAddr | input | 48 | Destination address, byte k at bits 8k+7:8k |
| hashSel | input | 2 | Hash window offset select |
| done | output | 1 | Result valid pulse |
| accept | output | 1 | Frame accepted |
| slotHit | output | 1 | Acceptance came from an exact slot |
| slotIdx | output | 4 | Lowest matching slot |
| mcastCount | output | CNT_W | Saturating hash-acceptance counter |

## Verification
The assertions assume that `lookupStb` is a single-cycle pulse whose `dstAddr` and `hashSel` are steady at the sampling edge. They also assume that reset is asserted from time zero. The bench changes inputs only on the falling edge and keeps every strobe high for exactly one cycle. It never overlaps a table write with a lookup whose result depends on that write, so each expected value follows from the table contents that existed before the strobe.

// File: rtl/daf_pkg.sv
package daf_pkg;

  // Control-to-datapath strobes for one lookup
  typedef struct packed {
    logic capture;  // latch the lookup decision
    logic bumpMc;   // count a hash-only acceptance
  } dafStrobes_t;

  // Right-shift applied to {byte5,byte4} for each window select
  function automatic logic [3:0] windowShift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd4;
      2'd1:    return 4'd3;
      2'd2:    return 4'd2;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/daf_ctrl.sv
module daf_ctrl
  import daf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        lookupStb,
  input  logic        exactAny,
  input  logic        hashBit,
  output dafStrobes_t strobes,
  output logic        done
);

  always_comb begin
    strobes.capture = lookupStb;
    strobes.bumpMc  = lookupStb & ~exactAny & hashBit;
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= lookupStb;
  end

  // R11: done is raised only in the cycle after a strobe
  p_done_after_stb_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(lookupStb));

endmodule

// File: rtl/daf_datapath.sv
module daf_datapath
  import daf_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int HASH_WORDS = 128,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [31:0]                  wrData,
  input  logic [47:0]                  dstAddr,
  input  logic [1:0]                   hashSel,
  input  dafStrobes_t                  strobes,
  output logic                         exactAny,
  output logic                         hashBit,
  output logic                         accept,
  output logic                         slotHit,
  output logic [$clog2(NUM_SLOTS)-1:0] slotIdx,
  output logic [CNT_W-1:0]             mcastCount
);

  localparam int IDX_W   = $clog2(NUM_SLOTS);
  localparam int HWORD_W = $clog2(HASH_WORDS);
  localparam int HASH_W  = HWORD_W + 5;

  logic [31:0] slotLo  [NUM_SLOTS];
  logic [15:0] slotHi  [NUM_SLOTS];
  logic        slotVal [NUM_SLOTS];
  logic [31:0] hashTbl [HASH_WORDS];
  logic [NUM_SLOTS-1:0] hitVec;

  wire hashSpace = wrAddr[ADDR_W-1];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    wire selSlot = wrEn && !hashSpace && (wrAddr[IDX_W:1] == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (rst) begin
        slotLo[s]  <= '0;
        slotHi[s]  <= '0;
        slotVal[s] <= 1'b0;
      end else if (selSlot) begin
        if (wrAddr[0]) begin
          slotHi[s]  <= wrData[15:0];
          slotVal[s] <= wrData[31];
        end else begin
          slotLo[s] <= wrData;
        end
      end
    end
    assign hitVec[s] = slotVal[s] && ({slotHi[s], slotLo[s]} == dstAddr);
  end

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    always_ff @(posedge clk) begin
      if (rst) hashTbl[w] <= '0;
      else if (wrEn && hashSpace && wrAddr[HWORD_W-1:0] == HWORD_W'(w))
        hashTbl[w] <= wrData;
    end
  end

  // Lowest-numbered matching slot wins
  logic [IDX_W-1:0] firstIdx;
  always_comb begin
    firstIdx = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (hitVec[s]) firstIdx = IDX_W'(s);
  end
  assign exactAny = |hitVec;

  logic [15:0]       hashSrc;
  logic [HASH_W-1:0] hashIdx;
  always_comb begin
    hashSrc = dstAddr[47:32] >> windowShift(hashSel);
    hashIdx = hashSrc[HASH_W-1:0];
    hashBit = hashTbl[hashIdx[HASH_W-1:5]][hashIdx[4:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accept     <= 1'b0;
      slotHit    <= 1'b0;
      slotIdx    <= '0;
      mcastCount <= '0;
    end else begin
      if (strobes.capture) begin
        accept  <= exactAny | hashBit;
        slotHit <= exactAny;
        slotIdx <= exactAny ? firstIdx : '0;
      end
      if (strobes.bumpMc && mcastCount != '1)
        mcastCount <= mcastCount + 1'b1;
    end
  end

  // R3: a slot hit is always an acceptance
  p_slot_implies_accept_r3: assert property (@(posedge clk) disable iff (rst)
    slotHit |-> accept);

  // R9: counter moves by at most one and never backwards
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (mcastCount == $past(mcastCount)) || (mcastCount == $past(mcastCount) + 1'b1));

  // R8: counting only on acceptances not owned by a slot
  p_count_excl_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (mcastCount != $past(mcastCount)) |-> (accept && !slotHit));

  // R11: decision outputs only change on a capture
  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable({accept, slotHit, slotIdx}) |-> $past(strobes.capture));

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import daf_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int HASH_WORDS = 128,
  parameter int CNT_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wrEn,
  input  logic [7:0]                   wrAddr,
  input  logic [31:0]                  wrData,
  input  logic                         lookupStb,
  input  logic [47:0]                  dstAddr,
  input  logic [1:0]                   hashSel,
  output logic                         done,
  output logic                         accept,
  output logic                         slotHit,
  output logic [$clog2(NUM_SLOTS)-1:0] slotIdx,
  output logic [CNT_W-1:0]             mcastCount
);

  dafStrobes_t strobes;
  logic        exactAny;
  logic        hashBit;

  daf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .lookupStb(lookupStb),
    .exactAny(exactAny), .hashBit(hashBit),
    .strobes(strobes), .done(done)
  );

  daf_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .HASH_WORDS(HASH_WORDS),
    .CNT_W(CNT_W), .ADDR_W(8)
  ) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dstAddr(dstAddr), .hashSel(hashSel), .strobes(strobes),
    .exactAny(exactAny), .hashBit(hashBit), .accept(accept),
    .slotHit(slotHit), .slotIdx(slotIdx), .mcastCount(mcastCount)
  );

endmodule

// File: tb/dst_addr_filter_tb.sv
`timescale 1ns/1ps
module dst_addr_filter_tb;

  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = '1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        lookupStb = 1'b0;
  logic [47:0] dstAddr = '0;
  logic [1:0]  hashSel = '0;
  logic        done, accept, slotHit;
  logic [3:0]  slotIdx;
  logic [CW-1:0] mcastCount;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] expCnt = '0;

  always #2.5 clk = ~clk;

  dst_addr_filter #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lookupStb(lookupStb), .dstAddr(dstAddr), .hashSel(hashSel),
    .done(done), .accept(accept), .slotHit(slotHit), .slotIdx(slotIdx),
    .mcastCount(mcastCount)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setSlot(input int s, input logic [47:0] a, input logic v);
    wr(8'(2 * s), a[31:0]);
    wr(8'(2 * s + 1), {v, 15'd0, a[47:32]});
  endtask

  task automatic look(input logic [47:0] a, input logic [1:0] s);
    @(negedge clk);
    dstAddr = a; hashSel = s; lookupStb = 1'b1;
    @(negedge clk);
    lookupStb = 1'b0;
  endtask

  function automatic logic [11:0] hashOf(input logic [47:0] a, input logic [1:0] s);
    int sh;
    sh = (s == 0) ? 4 : (s == 1) ? 3 : (s == 2) ? 2 : 0;
    return 12'((a[47:32] >> sh) & 16'h0fff);
  endfunction

  function automatic int shiftOf(input logic [1:0] s);
    return (s == 0) ? 4 : (s == 1) ? 3 : (s == 2) ? 2 : 0;
  endfunction

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] addrA, addrB, addrM, nb;
    logic [11:0] h;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 accept", accept, 0);
    chk("R1 count", mcastCount, 0);
    look(48'h0, 2'd0);
    chk("R1 zero addr rejected", accept, 0);
    look(48'h1234_5678_9abc, 2'd3);
    chk("R1 arbitrary rejected", accept, 0);

    // R2/R3 exact slot
    addrA = 48'h6655_4433_2211;
    setSlot(5, addrA, 1'b1);
    look(addrA, 2'd0);
    chk("R11 done", done, 1);
    chk("R3 accept", accept, 1);
    chk("R3 slotHit", slotHit, 1);
    chk("R2 slotIdx", slotIdx, 5);
    chk("R8 count unchanged", mcastCount, 0);
    for (int k = 0; k < 6; k++) begin
      nb = addrA ^ (48'h01 << (8 * k));
      look(nb, 2'd0);
      chk($sformatf("R10 byte %0d differs", k), {accept, slotHit}, 2'b00);
    end
    // R11 hold and single-cycle done
    look(addrA, 2'd0);
    @(negedge clk);
    chk("R11 done drops", done, 0);
    chk("R11 held", {accept, slotHit, slotIdx}, {2'b11, 4'd5});

    // R4 invalid slot skipped
    wr(8'd11, {1'b0, 15'd0, addrA[47:32]});
    look(addrA, 2'd0);
    chk("R4 invalid skipped", accept, 0);

    // R5 lowest index
    addrB = 48'hde01_beef_cafe;
    setSlot(9, addrB, 1'b1);
    setSlot(3, addrB, 1'b1);
    look(addrB, 2'd1);
    chk("R5 lowest idx", {accept, slotHit, slotIdx}, {2'b11, 4'd3});
    wr(8'd7, 32'h0);
    look(addrB, 2'd1);
    chk("R5 next slot", {accept, slotHit, slotIdx}, {2'b11, 4'd9});

    // R8 exact beats hash
    h = hashOf(addrB, 2'd0);
    wr(8'(128 + h[11:5]), 32'h1 << h[4:0]);
    look(addrB, 2'd0);
    chk("R8 slot wins", {accept, slotHit, slotIdx}, {2'b11, 4'd9});
    chk("R8 no count", mcastCount, expCnt);
    wr(8'(128 + h[11:5]), 32'h0);

    // R6/R7/R9 hash sweep over all window selects
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 8; k++) begin
        addrM = {8'(k * 53 + 7 + s * 17), 8'(k * 29 + 8'h35), 32'h00aa_bb01};
        h = hashOf(addrM, 2'(s));
        wr(8'(128 + h[11:5]), 32'h1 << h[4:0]);
        look(addrM, 2'(s));
        expCnt = (expCnt == CMAX) ? CMAX : expCnt + 1'b1;
        chk($sformatf("R6 R7 hit sel%0d k%0d", s, k), {accept, slotHit}, 2'b10);
        chk($sformatf("R9 count sel%0d k%0d", s, k), mcastCount, expCnt);
        nb = addrM ^ (48'h1 << (32 + shiftOf(2'(s))));
        look(nb, 2'(s));
        chk($sformatf("R7 neighbour bit sel%0d k%0d", s, k), accept, 0);
        chk($sformatf("R10 count kept sel%0d k%0d", s, k), mcastCount, expCnt);
        wr(8'(128 + h[11:5]), 32'h0);
      end
    end
    chk("R9 saturated", mcastCount, CMAX);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule